// File: doc/BRIEF.md
# Banked Working-Register RAM with Hardware Stack

This block is a 128-byte on-chip data RAM that serves three kinds of client at once. A direct port reads and writes any byte by its 8-bit address. A working-register port names one of eight registers by a 3-bit index; that index is turned into a RAM address through the bank currently chosen by two bits of an external status word. A push/pop port runs an upward-growing stack that lives in the same RAM, with its position held in an internal 8-bit stack pointer.

The four register banks take the lowest 32 bytes, and the stack starts just above bank 0 after reset. Software can move the stack by loading a new pointer value. The RAM has one write port and three registered read ports, so it maps onto distributed memory. When several clients want to write in the same cycle, a fixed priority decides which write lands. Any access that falls outside the RAM raises a one-cycle error flag and leaves the memory untouched.

Top module: `bankreg_ram`

## Requirements
- R1: While `rst` is high at a clock edge, `sp_out` becomes 0x07 and `err`, `dir_rdata`, `reg_rdata` and `pop_data` become 0.
- R2: A working-register access with index n and bank b = `status_in[4:3]` touches RAM address b*8 + n. The other status bits have no effect. Read data appears on `reg_rdata` one cycle after the request.
- R3: A direct access to an address from 0x00 to 0x7F writes `dir_wdata` when `dir_we` is 1. It shows the byte on `dir_rdata` one cycle later. A read in the same cycle as a write to the same byte returns the old byte.
- R4: A push adds 1 to the stack pointer and stores `push_data` at the new pointer value.
- R5: A pop shows the byte at the current pointer on `pop_data` one cycle later and subtracts 1 from the pointer. `pop_data` holds its value when no pop is carried out.
- R6: Stack pointer arithmetic wraps modulo 256. A push whose new pointer is above 0x7F, or a pop whose pointer is above 0x7F, still moves the pointer. It sets `err` for one cycle and writes nothing. An out-of-range pop drives `pop_data` to 0.
- R7: A direct access to an address above 0x7F sets `err` for one cycle, drives `dir_rdata` to 0, and writes nothing.
- R8: `sp_load` loads `sp_load_val` into the pointer. It overrides push and pop in the same cycle, which then neither write RAM nor change `pop_data`.
- R9: When push and pop are requested together without `sp_load`, only the push is carried out.
- R10: The single write port goes to a carried-out push first, then to a direct write request, then to a register write. A losing write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_in | input | 8 | Status word; bits 4:3 select the bank |
| dir_en | input | 1 | Direct access request |
| dir_we | input | 1 | Direct access is a write |
| dir_addr | input | 8 | Direct byte address |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Direct read data (registered) |
| reg_en | input | 1 | Working-register access request |
| reg_we | input | 1 | Working-register access is a write |
| reg_idx | input | 3 | Register index within the bank |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (registered) |
| sp_load | input | 1 | Load stack pointer |
| sp_load_val | input | 8 | New stack pointer value |
| push | input | 1 | Push request |
| push_data | input | 8 | Byte to push |
| pop | input | 1 | Pop request |
| pop_data | output | 8 | Popped byte (registered) |
| sp_out | output | 8 | Current stack pointer |
| err | output | 1 | Out-of-range access in the previous cycle |

## Verification
The pairs that can meet in one cycle are a stack operation and another stack operation, and a push and a direct or register write fighting for the one write port. The bench raises `sp_load`, `push` and `pop` together, then `push` with `pop`, then a push with a direct write and a register write to three different addresses, and last a direct write with a register write. Each result is judged after the fact. The bench reads the pointer from `sp_out`, reads every target byte back through the direct port, and compares `pop_data` with its previous value. So a write that was meant to be dropped, or a pointer step that was meant to be skipped, shows up at the ports.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  typedef enum logic [1:0] {
    WSRC_NONE,
    WSRC_PUSH,
    WSRC_DIR,
    WSRC_REG
  } wsrc_e;
endpackage

// File: rtl/bankreg_map.sv
module bankreg_map #(
  parameter int ADDR_W        = 8,
  parameter int STAT_W        = 8,
  parameter int NUM_BANKS     = 4,
  parameter int REGS_PER_BANK = 8,
  parameter int BANK_LSB      = 3
) (
  input  logic [STAT_W-1:0]                    status_in,
  input  logic [$clog2(REGS_PER_BANK)-1:0]     idx,
  output logic [ADDR_W-1:0]                    addr
);
  localparam int BSEL_W = $clog2(NUM_BANKS);
  localparam int IDX_W  = $clog2(REGS_PER_BANK);

  logic [BSEL_W-1:0] bank;

  assign bank = status_in[BANK_LSB +: BSEL_W];
  assign addr = ADDR_W'({bank, idx});
endmodule

// File: rtl/bankreg_sp.sv
module bankreg_sp #(
  parameter int          ADDR_W    = 8,
  parameter int          RAM_DEPTH = 128,
  parameter logic [7:0]  SP_RESET  = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sp_load,
  input  logic [ADDR_W-1:0] sp_load_val,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] sp,
  output logic              push_act,
  output logic              pop_act,
  output logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] pop_addr,
  output logic              push_ok,
  output logic              pop_ok
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(RAM_DEPTH);

  assign push_act  = push & ~sp_load;
  assign pop_act   = pop & ~push & ~sp_load;
  assign push_addr = sp + ADDR_W'(1);
  assign pop_addr  = sp;
  assign push_ok   = {1'b0, push_addr} < LIMIT;
  assign pop_ok    = {1'b0, pop_addr} < LIMIT;

  always_ff @(posedge clk) begin
    if (rst)           sp <= ADDR_W'(SP_RESET);
    else if (sp_load)  sp <= sp_load_val;
    else if (push_act) sp <= push_addr;
    else if (pop_act)  sp <= sp - ADDR_W'(1);
  end
endmodule

// File: rtl/bankreg_mem.sv
module bankreg_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int NRD    = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   we,
  input  logic [$clog2(DEPTH)-1:0]               waddr,
  input  logic [DATA_W-1:0]                      wdata,
  input  logic [NRD-1:0]                         rd_en,
  input  logic [NRD-1:0]                         rd_ok,
  input  logic [NRD-1:0][$clog2(DEPTH)-1:0]      rd_addr,
  output logic [NRD-1:0][DATA_W-1:0]             rd_q
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst)            rd_q[g] <= '0;
      else if (rd_en[g])  rd_q[g] <= rd_ok[g] ? mem[rd_addr[g]] : '0;
    end
  end
endmodule

// File: rtl/bankreg_ram.sv
module bankreg_ram
  import bankreg_pkg::*;
#(
  parameter int          DATA_W        = 8,
  parameter int          ADDR_W        = 8,
  parameter int          STAT_W        = 8,
  parameter int          RAM_DEPTH     = 128,
  parameter int          NUM_BANKS     = 4,
  parameter int          REGS_PER_BANK = 8,
  parameter int          BANK_LSB      = 3,
  parameter logic [7:0]  SP_RESET      = 8'h07
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [STAT_W-1:0]                 status_in,
  input  logic                              dir_en,
  input  logic                              dir_we,
  input  logic [ADDR_W-1:0]                 dir_addr,
  input  logic [DATA_W-1:0]                 dir_wdata,
  output logic [DATA_W-1:0]                 dir_rdata,
  input  logic                              reg_en,
  input  logic                              reg_we,
  input  logic [$clog2(REGS_PER_BANK)-1:0]  reg_idx,
  input  logic [DATA_W-1:0]                 reg_wdata,
  output logic [DATA_W-1:0]                 reg_rdata,
  input  logic                              sp_load,
  input  logic [ADDR_W-1:0]                 sp_load_val,
  input  logic                              push,
  input  logic [DATA_W-1:0]                 push_data,
  input  logic                              pop,
  output logic [DATA_W-1:0]                 pop_data,
  output logic [ADDR_W-1:0]                 sp_out,
  output logic                              err
);
  localparam int              MEM_AW = $clog2(RAM_DEPTH);
  localparam int              NRD    = 3;
  localparam int              RP_DIR = 0;
  localparam int              RP_REG = 1;
  localparam int              RP_POP = 2;
  localparam logic [ADDR_W:0] LIMIT  = (ADDR_W+1)'(RAM_DEPTH);

  logic [ADDR_W-1:0] reg_addr, push_addr, pop_addr;
  logic              push_act, pop_act, push_ok, pop_ok, dir_ok;
  wsrc_e             wsrc;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [NRD-1:0]                    rd_en, rd_ok;
  logic [NRD-1:0][MEM_AW-1:0]        rd_addr;
  logic [NRD-1:0][DATA_W-1:0]        rd_q;

  bankreg_map #(
    .ADDR_W(ADDR_W), .STAT_W(STAT_W), .NUM_BANKS(NUM_BANKS),
    .REGS_PER_BANK(REGS_PER_BANK), .BANK_LSB(BANK_LSB)
  ) u_map (
    .status_in(status_in), .idx(reg_idx), .addr(reg_addr)
  );

  bankreg_sp #(
    .ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH), .SP_RESET(SP_RESET)
  ) u_sp (
    .clk(clk), .rst(rst), .sp_load(sp_load), .sp_load_val(sp_load_val),
    .push(push), .pop(pop), .sp(sp_out), .push_act(push_act),
    .pop_act(pop_act), .push_addr(push_addr), .pop_addr(pop_addr),
    .push_ok(push_ok), .pop_ok(pop_ok)
  );

  assign dir_ok = {1'b0, dir_addr} < LIMIT;

  // Write-port arbitration: stack push, then direct, then register.
  always_comb begin
    wsrc = WSRC_NONE;
    if (push_act)                wsrc = push_ok ? WSRC_PUSH : WSRC_NONE;
    else if (dir_en && dir_we)   wsrc = dir_ok ? WSRC_DIR : WSRC_NONE;
    else if (reg_en && reg_we)   wsrc = WSRC_REG;
  end

  always_comb begin
    mem_we    = 1'b1;
    mem_waddr = '0;
    mem_wdata = '0;
    unique case (wsrc)
      WSRC_PUSH: begin mem_waddr = push_addr[MEM_AW-1:0]; mem_wdata = push_data; end
      WSRC_DIR:  begin mem_waddr = dir_addr[MEM_AW-1:0];  mem_wdata = dir_wdata; end
      WSRC_REG:  begin mem_waddr = reg_addr[MEM_AW-1:0];  mem_wdata = reg_wdata; end
      default:   mem_we = 1'b0;
    endcase
  end

  assign rd_en[RP_DIR]   = dir_en;
  assign rd_ok[RP_DIR]   = dir_ok;
  assign rd_addr[RP_DIR] = dir_addr[MEM_AW-1:0];
  assign rd_en[RP_REG]   = reg_en;
  assign rd_ok[RP_REG]   = 1'b1;
  assign rd_addr[RP_REG] = reg_addr[MEM_AW-1:0];
  assign rd_en[RP_POP]   = pop_act;
  assign rd_ok[RP_POP]   = pop_ok;
  assign rd_addr[RP_POP] = pop_addr[MEM_AW-1:0];

  bankreg_mem #(
    .DATA_W(DATA_W), .DEPTH(RAM_DEPTH), .NRD(NRD)
  ) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .rd_en(rd_en), .rd_ok(rd_ok), .rd_addr(rd_addr), .rd_q(rd_q)
  );

  assign dir_rdata = rd_q[RP_DIR];
  assign reg_rdata = rd_q[RP_REG];
  assign pop_data  = rd_q[RP_POP];

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= (push_act & ~push_ok) | (pop_act & ~pop_ok) | (dir_en & ~dir_ok);
  end
endmodule

// File: rtl/bankreg_chk.sv
module bankreg_chk #(
  parameter int RAM_DEPTH = 128
) (
  input logic       clk,
  input logic       rst,
  input logic       dir_en,
  input logic [7:0] dir_addr,
  input logic       sp_load,
  input logic [7:0] sp_load_val,
  input logic       push,
  input logic       pop,
  input logic [7:0] sp_out,
  input logic       err
);
  localparam logic [7:0] TOP = 8'(RAM_DEPTH - 1);

  p_sp_reset_r1: assert property (@(posedge clk) rst |=> (sp_out == 8'h07 && !err));

  p_push_step_r4: assert property (@(posedge clk) disable iff (rst)
    (push && !sp_load) |=> (sp_out == 8'($past(sp_out) + 8'd1)));

  p_pop_step_r5: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !sp_load) |=> (sp_out == 8'($past(sp_out) - 8'd1)));

  p_push_range_r6: assert property (@(posedge clk) disable iff (rst)
    (push && !sp_load && sp_out >= TOP && sp_out != 8'hFF) |=> err);

  p_sp_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop && !sp_load) |=> $stable(sp_out));

  p_dir_range_r7: assert property (@(posedge clk) disable iff (rst)
    (dir_en && dir_addr > TOP) |=> err);

  p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
    sp_load |=> (sp_out == $past(sp_load_val)));
endmodule

bind bankreg_ram bankreg_chk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (.*);

// File: tb/test_bankreg_ram.sv
module test_bankreg_ram;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] status_in;
  logic       dir_en, dir_we;
  logic [7:0] dir_addr, dir_wdata, dir_rdata;
  logic       reg_en, reg_we;
  logic [2:0] reg_idx;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sp_load;
  logic [7:0] sp_load_val;
  logic       push, pop;
  logic [7:0] push_data, pop_data, sp_out;
  logic       err;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [128];
  logic [7:0] d, prev_pop;

  always #5 clk = ~clk;

  bankreg_ram i_bankreg_ram (.*);

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic clr;
    dir_en = 0; dir_we = 0; dir_addr = 0; dir_wdata = 0;
    reg_en = 0; reg_we = 0; reg_idx = 0; reg_wdata = 0;
    sp_load = 0; sp_load_val = 0; push = 0; pop = 0; push_data = 0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic dwrite(input logic [7:0] a, input logic [7:0] v);
    dir_en = 1; dir_we = 1; dir_addr = a; dir_wdata = v;
    tick;
    clr;
    if (a < 8'h80) model[a[6:0]] = v;
  endtask

  task automatic dread(input logic [7:0] a, output logic [7:0] v);
    dir_en = 1; dir_we = 0; dir_addr = a;
    tick;
    v = dir_rdata;
    clr;
  endtask

  task automatic do_push(input logic [7:0] v);
    push = 1; push_data = v;
    tick;
    clr;
  endtask

  task automatic do_load(input logic [7:0] v);
    sp_load = 1; sp_load_val = v;
    tick;
    clr;
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    clr;
    status_in = 8'h00;
    rst = 1;
    tick; tick;
    chk("R1 sp", sp_out, 8'h07);
    chk("R1 err", {7'd0, err}, 8'h00);
    chk("R1 dir_rdata", dir_rdata, 8'h00);
    chk("R1 reg_rdata", reg_rdata, 8'h00);
    chk("R1 pop_data", pop_data, 8'h00);
    rst = 0;

    // R3: full direct sweep
    for (int a = 0; a < 128; a++) dwrite(8'(a), 8'(a * 7 + 3));
    for (int a = 0; a < 128; a++) begin
      dread(8'(a), d);
      chk("R3 sweep", d, model[a]);
    end
    // R3: read returns old byte during same-cycle write
    dir_en = 1; dir_we = 1; dir_addr = 8'h05; dir_wdata = ~model[5];
    tick;
    chk("R3 read-before-write", dir_rdata, model[5]);
    model[5] = ~model[5];
    clr;
    dread(8'h05, d);
    chk("R3 new value", d, model[5]);

    // R2: bank mapping with noise in other status bits
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++) begin
        status_in = 8'(b << 3) | 8'hE7;
        reg_en = 1; reg_we = 1; reg_idx = 3'(n); reg_wdata = 8'(8'hA0 + b * 16 + n);
        tick;
        clr;
        model[b * 8 + n] = 8'(8'hA0 + b * 16 + n);
      end
    for (int a = 0; a < 32; a++) begin
      dread(8'(a), d);
      chk("R2 direct view", d, model[a]);
    end
    for (int a = 0; a < 32; a++) dwrite(8'(a), 8'(a * 13 + 1));
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++) begin
        status_in = 8'(b << 3) | 8'h27;
        reg_en = 1; reg_we = 0; reg_idx = 3'(n);
        tick;
        chk("R2 reg read", reg_rdata, model[b * 8 + n]);
        clr;
      end

    // R4: push
    for (int k = 0; k < 3; k++) begin
      do_push(8'(8'h50 + k));
      chk("R4 sp step", sp_out, 8'(8 + k));
      model[8 + k] = 8'(8'h50 + k);
    end
    for (int k = 0; k < 3; k++) begin
      dread(8'(8 + k), d);
      chk("R4 stored", d, model[8 + k]);
    end
    // R5: pop
    for (int k = 0; k < 3; k++) begin
      pop = 1;
      tick;
      chk("R5 pop data", pop_data, model[10 - k]);
      chk("R5 sp step", sp_out, 8'(9 - k));
      clr;
    end
    tick;
    chk("R5 hold", pop_data, model[8]);

    // R6: top of RAM
    do_load(8'h7E);
    chk("R8 load", sp_out, 8'h7E);
    do_push(8'h11);
    chk("R6 last in range sp", sp_out, 8'h7F);
    chk("R6 last in range err", {7'd0, err}, 8'h00);
    model[127] = 8'h11;
    do_push(8'h22);
    chk("R6 overflow sp", sp_out, 8'h80);
    chk("R6 overflow err", {7'd0, err}, 8'h01);
    dread(8'h00, d);
    chk("R6 no stray write", d, model[0]);
    pop = 1;
    tick;
    chk("R6 oob pop err", {7'd0, err}, 8'h01);
    chk("R6 oob pop data", pop_data, 8'h00);
    chk("R6 oob pop sp", sp_out, 8'h7F);
    clr;
    pop = 1;
    tick;
    chk("R6 pop back data", pop_data, 8'h11);
    chk("R6 pop back err", {7'd0, err}, 8'h00);
    clr;
    // R6: wrap
    do_load(8'hFF);
    do_push(8'h33);
    chk("R6 wrap up sp", sp_out, 8'h00);
    chk("R6 wrap up err", {7'd0, err}, 8'h00);
    model[0] = 8'h33;
    dread(8'h00, d);
    chk("R6 wrap stored", d, 8'h33);
    pop = 1;
    tick;
    chk("R6 wrap down sp", sp_out, 8'hFF);
    chk("R6 wrap pop data", pop_data, 8'h33);
    clr;

    // R7: direct access above RAM
    dir_en = 1; dir_we = 1; dir_addr = 8'h80; dir_wdata = 8'h99;
    tick;
    chk("R7 write err", {7'd0, err}, 8'h01);
    chk("R7 rdata zero", dir_rdata, 8'h00);
    clr;
    dread(8'h00, d);
    chk("R7 no alias write", d, model[0]);
    dread(8'hC5, d);
    chk("R7 read zero", d, 8'h00);
    chk("R7 read err", {7'd0, err}, 8'h01);

    // R8: load beats push and pop
    do_load(8'h20);
    prev_pop = pop_data;
    sp_load = 1; sp_load_val = 8'h40; push = 1; push_data = 8'hEE; pop = 1;
    tick;
    chk("R8 sp", sp_out, 8'h40);
    chk("R8 pop_data kept", pop_data, prev_pop);
    clr;
    dread(8'h21, d);
    chk("R8 no push write", d, model[8'h21]);

    // R9: push beats pop
    push = 1; push_data = 8'h77; pop = 1;
    tick;
    chk("R9 sp", sp_out, 8'h41);
    chk("R9 pop_data kept", pop_data, prev_pop);
    clr;
    model[8'h41] = 8'h77;
    dread(8'h41, d);
    chk("R9 stored", d, 8'h77);

    // R10: write port contention
    status_in = 8'h10;
    push = 1; push_data = 8'h12;
    dir_en = 1; dir_we = 1; dir_addr = 8'h60; dir_wdata = 8'h34;
    reg_en = 1; reg_we = 1; reg_idx = 3'd3; reg_wdata = 8'h56;
    tick;
    clr;
    model[8'h42] = 8'h12;
    dread(8'h42, d);
    chk("R10 push wins", d, 8'h12);
    dread(8'h60, d);
    chk("R10 direct dropped", d, model[8'h60]);
    dread(8'h13, d);
    chk("R10 reg dropped", d, model[8'h13]);
    dir_en = 1; dir_we = 1; dir_addr = 8'h61; dir_wdata = 8'h9A;
    reg_en = 1; reg_we = 1; reg_idx = 3'd4; reg_wdata = 8'hBC;
    tick;
    clr;
    model[8'h61] = 8'h9A;
    dread(8'h61, d);
    chk("R10 direct wins", d, 8'h9A);
    dread(8'h14, d);
    chk("R10 reg dropped 2", d, model[8'h14]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule